// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block generates the timing skeleton for a two-channel pulse-width modulator. The input clock is first divided into ticks by a prescaler built from two cascaded stages: a fast stage that divides by one or by an even number, and a coarse stage that divides by a power of two. On every tick a 16-bit counter steps according to the selected count mode. The counter can count up, count down, or count up and then down, and it can also be frozen.

The block reports the counter value together with single-cycle strobes. One strobe marks the counter reaching zero, one marks it reaching the period, and two mark an upward crossing of compare value A (channel 0) and compare value B (channel 1). A downstream action stage turns these events into pin levels. Both channels share one period register. The period can be written straight into the active register, or it can be staged in a shadow register that is copied to the active register when the counter next reaches zero.

Software configures the block through a single write strobe with a 2-bit select. The write port has no read-back.

Top module: `pwm_timebase`

## Requirements
- R1: While `rst_n` is low and on the cycle after it is released, `count` is 0, all strobes and `step` are 0. Reset also selects up mode, immediate-load off (shadow mode), both divide codes 0, and clears the period and both compare values.
- R2: A write with `wr_en` high stores `wr_data` at the rising edge. `wr_sel` selects the target: 0 is the control word, 1 the period, 2 compare A and 3 compare B. Control fields: bits 1:0 count mode, bit 3 immediate period load, bits 9:7 fast divide code h, bits 12:10 coarse divide code c. All other control bits are ignored.
- R3: In up mode (mode 00) the counter increments on each tick. On the tick after it equals the period it returns to 0. If it is ever above the period (after an immediate shrink), the next tick also returns it to 0.
- R4: In down mode (mode 01) the counter decrements on each tick. On the tick after it equals 0 it loads the period.
- R5: In up-down mode (mode 10) the counter rises to the period, then falls to 0, and repeats. Each end value is held for exactly one tick before the direction reverses.
- R6: A tick occurs once every 2^c × D input clocks, where D is 1 for h = 0 and 2h otherwise. Writing the control word restarts the prescaler, so the first tick after such a write comes D × 2^c cycles after it. `step` pulses for one clock in the cycle after each tick.
- R7: With control bit 3 set, a period write takes effect for the counter from the next clock.
- R8: With control bit 3 clear, a period write goes to a shadow register. The counter keeps using the old period until a tick moves the counter to 0; from then on the shadow value is used.
- R9: `at_zero` and `at_period` are each high for one clock, together with `step`, when the counter has just moved to 0 or to the active period respectively.
- R10: `cmp_hit[0]` (compare A) and `cmp_hit[1]` (compare B) pulse together with `step` when the counter has just been incremented onto the compare value. Arrivals by decrement, by wrap or by reload never raise them.
- R11: In freeze mode (mode 11) the counter holds its value and no zero, period or compare strobe fires. `step` still pulses, and a shadowed period is not loaded.
- R12: With a period of 0 the counter stays at 0 in every counting mode. It raises `at_zero` and `at_period` on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 period, 2 compare A, 3 compare B |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| step | output | 1 | One-clock pulse in the cycle after each prescaled tick |
| at_zero | output | 1 | Counter has just moved to zero |
| at_period | output | 1 | Counter has just moved to the active period |
| cmp_hit | output | 2 | Compare-up strobes, bit 0 channel A, bit 1 channel B |

## Verification
The assertions assume that register writes arrive only as whole-word strobes with a stable select and data for the sampled edge. They also assume that reset is held low for at least one clock before the first write, so that period and compare values seen through `$past` were stored by the block itself. The stimulus drives every input on the falling clock edge, holds `wr_en` for exactly one clock per write, and starts with a multi-cycle reset. It steps through each count mode, several divide-code pairs, immediate and shadowed period writes (including a shrink below the running count), a zero period, and freeze. A cycle-accurate expectation model built from the requirements predicts every output word.

// File: rtl/pwm_tb_pkg.sv
// Shared types and control-word field positions for the PWM time base.
// Assumes: control word layout is fixed; widths of data come from module parameters.
package pwm_tb_pkg;

    // Count modes held in control bits 1:0
    typedef enum logic [1:0] {
        MODE_UP   = 2'b00,
        MODE_DOWN = 2'b01,
        MODE_UPDN = 2'b10,
        MODE_HOLD = 2'b11
    } cnt_mode_e;

    // Write-port targets
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_PRD   = 2'd1,
        SEL_CMP_A = 2'd2,
        SEL_CMP_B = 2'd3
    } wr_target_e;

    // Control-word field positions
    localparam int MODE_LSB    = 0;
    localparam int PRD_LD_BIT  = 3;
    localparam int FAST_LSB    = 7;
    localparam int COARSE_LSB  = 10;

endpackage

// File: rtl/pwm_tb_regs.sv
// Configuration registers: control fields, shadow and active period, compare values.
// Assumes: one write per clock; zero_evt is the counter's "moved to zero" event.
module pwm_tb_regs
    import pwm_tb_pkg::*;
#(
    parameter int W      = 16,
    parameter int CODE_W = 3,
    parameter int NCH    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_sel,
    input  logic [W-1:0]              wr_data,
    input  logic                      zero_evt,
    output cnt_mode_e                 mode_q,
    output logic                      prd_direct,
    output logic [CODE_W-1:0]         fast_code,
    output logic [CODE_W-1:0]         coarse_code,
    output logic [W-1:0]              prd_act,
    output logic [NCH-1:0][W-1:0]     cmp_vals,
    output logic                      ctrl_wr
);

    logic [W-1:0] prd_shadow;
    logic         wr_ctrl, wr_prd;

    // Decode write targets
    always_comb begin
        wr_ctrl = wr_en && (wr_target_e'(wr_sel) == SEL_CTRL);
        wr_prd  = wr_en && (wr_target_e'(wr_sel) == SEL_PRD);
    end

    assign ctrl_wr = wr_ctrl;

    // Control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= MODE_UP;
            prd_direct  <= 1'b0;
            fast_code   <= '0;
            coarse_code <= '0;
        end else if (wr_ctrl) begin
            mode_q      <= cnt_mode_e'(wr_data[MODE_LSB +: 2]);
            prd_direct  <= wr_data[PRD_LD_BIT];
            fast_code   <= wr_data[FAST_LSB +: CODE_W];
            coarse_code <= wr_data[COARSE_LSB +: CODE_W];
        end
    end

    // Shadow period always takes the last written value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_shadow <= '0;
        end else if (wr_prd) begin
            prd_shadow <= wr_data;
        end
    end

    // Active period: direct write wins, else shadow copy on a zero event in shadow mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_act <= '0;
        end else if (wr_prd && prd_direct) begin
            prd_act <= wr_data;
        end else if (zero_evt && !prd_direct) begin
            prd_act <= prd_shadow;
        end
    end

    // One compare register per channel, select = SEL_CMP_A + channel
    for (genvar ch = 0; ch < NCH; ch++) begin : g_cmp
        localparam logic [1:0] MY_SEL = 2'(int'(SEL_CMP_A) + ch);
        // Store compare value for this channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_vals[ch] <= '0;
            end else if (wr_en && wr_sel == MY_SEL) begin
                cmp_vals[ch] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/pwm_tb_prescale.sv
// Two-stage tick prescaler: fast stage divides by 1 or 2h, coarse stage by 2^c.
// Assumes: codes are stable between control writes; restart pulses on each control write.
module pwm_tb_prescale #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [CODE_W-1:0] fast_code,
    input  logic [CODE_W-1:0] coarse_code,
    output logic              tick
);

    localparam int FW = CODE_W + 1;
    localparam int CW = (1 << CODE_W) - 1;

    logic [FW-1:0] fast_cnt, fast_top;
    logic [CW-1:0] coarse_cnt, coarse_top;
    logic          fast_wrap, coarse_wrap;

    // Terminal counts of both stages
    always_comb begin
        fast_top    = (fast_code == '0) ? '0 : ({fast_code, 1'b0} - FW'(1));
        coarse_top  = (CW'(1) << coarse_code) - CW'(1);
        fast_wrap   = (fast_cnt >= fast_top);
        coarse_wrap = (coarse_cnt >= coarse_top);
        tick        = fast_wrap && coarse_wrap;
    end

    // Fast stage counter
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            fast_cnt <= '0;
        end else if (fast_wrap) begin
            fast_cnt <= '0;
        end else begin
            fast_cnt <= fast_cnt + FW'(1);
        end
    end

    // Coarse stage counter, advanced by fast-stage wraps
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            coarse_cnt <= '0;
        end else if (fast_wrap) begin
            if (coarse_wrap) begin
                coarse_cnt <= '0;
            end else begin
                coarse_cnt <= coarse_cnt + CW'(1);
            end
        end
    end

endmodule

// File: rtl/pwm_tb_counter.sv
// Time-base counter: up, down, up-down and hold modes against the active period.
// Assumes: tick is a one-clock enable; period may change at any clock.
module pwm_tb_counter
    import pwm_tb_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  cnt_mode_e    mode,
    input  logic [W-1:0] prd,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_next,
    output logic         step_up,
    output logic         moving,
    output logic         zero_evt
);

    logic dir_up, dir_next;

    // Next-state selection per mode
    always_comb begin
        cnt_next = cnt;
        step_up  = 1'b0;
        dir_next = dir_up;
        unique case (mode)
            MODE_UP: begin
                dir_next = 1'b1;
                if (cnt >= prd) begin
                    cnt_next = '0;
                end else begin
                    cnt_next = cnt + W'(1);
                    step_up  = 1'b1;
                end
            end
            MODE_DOWN: begin
                dir_next = 1'b0;
                cnt_next = (cnt == '0) ? prd : cnt - W'(1);
            end
            MODE_UPDN: begin
                if (dir_up) begin
                    if (cnt >= prd) begin
                        cnt_next = (cnt == '0) ? '0 : cnt - W'(1);
                        dir_next = 1'b0;
                    end else begin
                        cnt_next = cnt + W'(1);
                        step_up  = 1'b1;
                    end
                end else begin
                    if (cnt == '0) begin
                        cnt_next = (prd == '0) ? '0 : W'(1);
                        step_up  = (prd != '0);
                        dir_next = 1'b1;
                    end else begin
                        cnt_next = cnt - W'(1);
                    end
                end
            end
            default: begin
                cnt_next = cnt;
            end
        endcase
        moving   = tick && (mode != MODE_HOLD);
        zero_evt = moving && (cnt_next == '0);
    end

    // Counter and direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dir_up <= 1'b1;
        end else if (moving) begin
            cnt    <= cnt_next;
            dir_up <= dir_next;
        end
    end

endmodule

// File: rtl/pwm_tb_events.sv
// Event strobes: tick echo, zero, period and per-channel compare-up, all one clock wide.
// Assumes: cnt_next/step_up/moving come from the counter in the same cycle.
module pwm_tb_events #(
    parameter int W   = 16,
    parameter int NCH = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  moving,
    input  logic                  step_up,
    input  logic [W-1:0]          cnt_next,
    input  logic [W-1:0]          prd,
    input  logic [NCH-1:0][W-1:0] cmp_vals,
    output logic                  step,
    output logic                  at_zero,
    output logic                  at_period,
    output logic [NCH-1:0]        cmp_hit
);

    // Zero, period and tick echo
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step      <= 1'b0;
            at_zero   <= 1'b0;
            at_period <= 1'b0;
        end else begin
            step      <= tick;
            at_zero   <= moving && (cnt_next == '0);
            at_period <= moving && (cnt_next == prd);
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_hit
        // Compare-up strobe for this channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_hit[ch] <= 1'b0;
            end else begin
                cmp_hit[ch] <= moving && step_up && (cnt_next == cmp_vals[ch]);
            end
        end
    end

endmodule

// File: rtl/pwm_timebase.sv
// Top of the PWM time base: registers, prescaler, counter and event strobes.
// Assumes: synchronous active-low reset; single write strobe with select.
module pwm_timebase
    import pwm_tb_pkg::*;
#(
    parameter int W      = 16,
    parameter int CODE_W = 3,
    parameter int NCH    = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [1:0]     wr_sel,
    input  logic [W-1:0]   wr_data,
    output logic [W-1:0]   count,
    output logic           step,
    output logic           at_zero,
    output logic           at_period,
    output logic [NCH-1:0] cmp_hit
);

    cnt_mode_e             mode_q;
    logic                  prd_direct;
    logic [CODE_W-1:0]     fast_code, coarse_code;
    logic [W-1:0]          prd_act;
    logic [NCH-1:0][W-1:0] cmp_vals;
    logic                  ctrl_wr, tick;
    logic [W-1:0]          cnt_next;
    logic                  step_up, moving, zero_evt;

    pwm_tb_regs #(.W(W), .CODE_W(CODE_W), .NCH(NCH)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .zero_evt    (zero_evt),
        .mode_q      (mode_q),
        .prd_direct  (prd_direct),
        .fast_code   (fast_code),
        .coarse_code (coarse_code),
        .prd_act     (prd_act),
        .cmp_vals    (cmp_vals),
        .ctrl_wr     (ctrl_wr)
    );

    pwm_tb_prescale #(.CODE_W(CODE_W)) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (ctrl_wr),
        .fast_code   (fast_code),
        .coarse_code (coarse_code),
        .tick        (tick)
    );

    pwm_tb_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (mode_q),
        .prd      (prd_act),
        .cnt      (count),
        .cnt_next (cnt_next),
        .step_up  (step_up),
        .moving   (moving),
        .zero_evt (zero_evt)
    );

    pwm_tb_events #(.W(W), .NCH(NCH)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .moving    (moving),
        .step_up   (step_up),
        .cnt_next  (cnt_next),
        .prd       (prd_act),
        .cmp_vals  (cmp_vals),
        .step      (step),
        .at_zero   (at_zero),
        .at_period (at_period),
        .cmp_hit   (cmp_hit)
    );

endmodule

// File: rtl/pwm_timebase_chk.sv
// Property checker for the PWM time base, bound into every pwm_timebase instance.
// Assumes: it sees the top-level ports plus the active period, first compare and mode.
module pwm_timebase_chk #(
    parameter int W   = 16,
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [1:0]     mode_bits,
    input logic [W-1:0]   count,
    input logic           step,
    input logic           at_zero,
    input logic           at_period,
    input logic [NCH-1:0] cmp_hit,
    input logic [W-1:0]   prd_act,
    input logic [W-1:0]   cmp_a
);

    AST_STROBE_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (at_zero || at_period || (|cmp_hit)) |-> step); // R9

    AST_ZERO_MEANS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        at_zero |-> (count == '0)); // R9

    AST_PERIOD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        at_period |-> (count == $past(prd_act))); // R9

    AST_CMP_A_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit[0] |-> (count == $past(cmp_a))); // R10

    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits == 2'b11) |=> $stable(count)); // R11

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits == 2'b11) |=> (!at_zero && !at_period && (cmp_hit == '0))); // R11

endmodule

bind pwm_timebase pwm_timebase_chk #(.W(W), .NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_bits (mode_q),
    .count     (count),
    .step      (step),
    .at_zero   (at_zero),
    .at_period (at_period),
    .cmp_hit   (cmp_hit),
    .prd_act   (prd_act),
    .cmp_a     (cmp_vals[0])
);

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] count;
    logic        step, at_zero, at_period;
    logic [1:0]  cmp_hit;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    // Expected output word: {step, count, zero, period, hitB, hitA}
    logic [20:0] exp_q[$];

    always #2.5 clk = ~clk;

    pwm_timebase dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .count(count), .step(step), .at_zero(at_zero), .at_period(at_period), .cmp_hit(cmp_hit)
    );

    // ---------------- expectation model, pushes one item per clock ----------------
    int m_cnt, m_mode, m_c, m_h, m_sh, m_act, m_ca, m_cb, m_pre;
    bit m_ld, m_dir;

    always @(posedge clk) begin
        int div, nxt, ndir;
        bit tk, mv, su, z, p, a, b;
        if (!rst_n) begin
            m_cnt = 0; m_mode = 0; m_c = 0; m_h = 0; m_sh = 0; m_act = 0;
            m_ca = 0; m_cb = 0; m_pre = 0; m_ld = 0; m_dir = 1;
            exp_q.push_back(21'd0);
        end else begin
            div = (1 << m_c) * ((m_h == 0) ? 1 : 2 * m_h);
            tk = (m_pre == div - 1);
            mv = tk && (m_mode != 3);
            nxt = m_cnt; su = 0; ndir = m_dir;
            case (m_mode)
                0: begin
                    ndir = 1;
                    if (m_cnt >= m_act) nxt = 0;
                    else begin nxt = m_cnt + 1; su = 1; end
                end
                1: begin
                    ndir = 0;
                    nxt = (m_cnt == 0) ? m_act : m_cnt - 1;
                end
                2: begin
                    if (m_dir) begin
                        if (m_cnt >= m_act) begin nxt = (m_cnt == 0) ? 0 : m_cnt - 1; ndir = 0; end
                        else begin nxt = m_cnt + 1; su = 1; end
                    end else begin
                        if (m_cnt == 0) begin nxt = (m_act == 0) ? 0 : 1; su = (m_act != 0); ndir = 1; end
                        else nxt = m_cnt - 1;
                    end
                end
                default: nxt = m_cnt;
            endcase
            z = mv && (nxt == 0);
            p = mv && (nxt == m_act);
            a = mv && su && (nxt == m_ca);
            b = mv && su && (nxt == m_cb);
            // period update: direct write wins, else shadow copy on zero event
            if (wr_en && wr_sel == 2'd1 && m_ld) m_act = wr_data;
            else if (z && !m_ld) m_act = m_sh;
            if (wr_en && wr_sel == 2'd1) m_sh = wr_data;
            if (wr_en && wr_sel == 2'd2) m_ca = wr_data;
            if (wr_en && wr_sel == 2'd3) m_cb = wr_data;
            if (wr_en && wr_sel == 2'd0) begin
                m_mode = wr_data[1:0]; m_ld = wr_data[3];
                m_h = wr_data[9:7]; m_c = wr_data[12:10]; m_pre = 0;
            end else begin
                m_pre = tk ? 0 : m_pre + 1;
            end
            if (mv) begin m_cnt = nxt; m_dir = ndir[0]; end
            exp_q.push_back({tk, 16'(nxt & 32'hFFFF) & (mv ? 16'hFFFF : 16'h0) | (mv ? 16'h0 : 16'(m_cnt)), z, p, b, a});
        end
    end

    // ---------------- monitor: pops and compares away from the active edge ----------------
    always @(negedge clk) begin
        logic [20:0] got, exp;
        if (exp_q.size() > 0) begin
            exp = exp_q.pop_front();
            got = {step, count, at_zero, at_period, cmp_hit[1], cmp_hit[0]};
            checks++;
            if (got !== exp) begin
                failures++;
                $display("FAIL %s t=%0t: step=%b cnt=%0d z=%b p=%b hitB=%b hitA=%b expected step=%b cnt=%0d z=%b p=%b hitB=%b hitA=%b",
                    cur_req, $time, got[20], got[19:4], got[3], got[2], got[1], got[0],
                    exp[20], exp[19:4], exp[3], exp[2], exp[1], exp[0]);
            end
        end
    end

    // ---------------- driver helpers ----------------
    function automatic logic [15:0] ctrl_word(int mode, bit direct, int c, int h);
        ctrl_word = 16'h0;
        ctrl_word[1:0]   = 2'(mode);
        ctrl_word[3]     = direct;
        ctrl_word[9:7]   = 3'(h);
        ctrl_word[12:10] = 3'(c);
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 16'h0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic direct_check(input string req, input bit ok, input int got, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    // Measure clocks between two step pulses (R6)
    task automatic spacing_check(input int expv);
        int n;
        n = 0;
        while (step !== 1'b1) @(negedge clk);
        @(negedge clk);
        n = 1;
        while (step !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
        direct_check("R6 tick spacing", n == expv, n, expv);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        cur_req = "R1";
        idle(3);
        // R1: outputs cleared while reset held
        direct_check("R1 count in reset", count == 16'd0, count, 0);
        direct_check("R1 strobes in reset", {step, at_zero, at_period, cmp_hit} == 5'd0,
                     {step, at_zero, at_period, cmp_hit}, 0);
        rst_n = 1'b1;
        cur_req = "R12 R9";
        idle(10);

        cur_req = "R2 R3 R7 R9 R10";
        wr(2'd0, ctrl_word(0, 1, 0, 0) | 16'hE074); // unused control bits set, ignored (R2)
        wr(2'd1, 16'd5);
        wr(2'd2, 16'd2);
        wr(2'd3, 16'd4);
        idle(30);
        cur_req = "R3 R7 shrink";
        wr(2'd1, 16'd3);
        idle(20);

        cur_req = "R4 R7 R10";
        wr(2'd0, ctrl_word(1, 1, 0, 0));
        wr(2'd1, 16'd6);
        idle(30);

        cur_req = "R5 R9 R10";
        wr(2'd0, ctrl_word(2, 1, 0, 0));
        wr(2'd1, 16'd7);
        wr(2'd2, 16'd3);
        wr(2'd3, 16'd7);
        idle(50);

        cur_req = "R12 updn";
        wr(2'd1, 16'd0);
        idle(12);

        cur_req = "R6";
        wr(2'd1, 16'd4);
        wr(2'd0, ctrl_word(0, 1, 1, 3));
        spacing_check(12);
        idle(150);
        wr(2'd0, ctrl_word(0, 1, 2, 0));
        spacing_check(4);
        idle(60);
        wr(2'd0, ctrl_word(2, 1, 0, 7));
        spacing_check(14);
        idle(100);
        wr(2'd0, ctrl_word(0, 1, 3, 1));
        spacing_check(16);
        idle(100);

        cur_req = "R8";
        wr(2'd0, ctrl_word(0, 0, 0, 0));
        wr(2'd1, 16'd9);
        idle(30);
        wr(2'd1, 16'd2);
        idle(30);
        wr(2'd0, ctrl_word(2, 0, 0, 0));
        wr(2'd1, 16'd5);
        idle(40);

        cur_req = "R11";
        wr(2'd0, ctrl_word(3, 0, 0, 0));
        wr(2'd1, 16'd8);
        idle(20);
        cur_req = "R11 R8 resume";
        wr(2'd0, ctrl_word(0, 0, 0, 0));
        idle(30);

        idle(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule